// File: doc/BRIEF.md
# Dual-Clock Compare-Match Timer Channel

A single 32-bit compare-match timer channel. Its counter, compare value and prescaler live in a slow reference clock domain. Control, counter and compare registers are read and written from a fast bus clock. Writes to the counter or the compare value are held in the bus domain and passed across by a toggle handshake. A write-pending bit in the control register stays set until the slow side has taken the value.

The counter either clears after it reaches the compare value (periodic mode) or keeps running and wraps (free-running mode). A wrap sets an overflow flag. Reaching the compare value sets a sticky match flag. A routing field sends the match flag to a DMA request output, to an interrupt output, or to neither. Counter reads return a coherent snapshot taken in the slow domain. Channel start and stop come from a single `run_i` input.

Top module: `cmt_chan`

## Requirements
- R1: Address 0 is control, 1 is counter, 2 is compare. After reset, control reads 0, counter reads 0 and compare reads 0xFFFFFFFF. A compare read returns the last accepted compare write.
- R2: A write to the counter or the compare register sets control bit 13 (write pending) from the next bus cycle. The bit clears only after the slow domain has applied the value. A counter read taken just after a counter write still shows the old value.
- R3: A write to the counter or the compare register is ignored while bit 13 is set.
- R4: Control bits [2:0] select the count rate. Code 4 counts every 8th reference cycle, 5 every 32nd, 6 every 128th and 7 every cycle. Codes 0 to 3 hold the counter, and so does `run_i` low.
- R5: With control bit 8 = 1 (periodic), the counter goes to 0 on the count step after it equals the compare value, and that step sets the match flag (bit 15).
- R6: With bit 8 = 0 (free-running), a count step at the compare value sets bit 15 and the counter goes on counting. A step from 0xFFFFFFFF to 0 sets the overflow flag (bit 14).
- R7: Bits 15 and 14 are sticky. A control write with 0 in a flag bit clears that flag, and a write with 1 leaves it unchanged.
- R8: Bits [5:4] route the match flag. With code 1, `dma_req_o` follows bit 15. With code 2, `irq_o` follows bit 15 AND bit 7 (interrupt enable). Codes 0 and 3 drive neither output.
- R9: Counter reads are coherent snapshots. In periodic mode with compare N, no read ever exceeds N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| ref_clk_i | input | 1 | Slow counting reference clock |
| run_i | input | 1 | Channel run enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational on addr_i) |
| dma_req_o | output | 1 | DMA request |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps all eight clock-select codes. For each code it measures the counter advance over 1024 reference cycles against the expected quotient, which tells the four dividers apart and shows that the four holding codes really hold. It runs a short periodic compare and checks the counter against it; with stopped time it issues back-to-back counter writes, so the readback separates the applied value, the stale value and the ignored one. It sets up a free-running start just below the wrap point, which separates overflow from a plain match. It also sweeps all routing codes with the interrupt enable both off and on.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int unsigned ADDR_W  = 2;
  localparam logic [1:0]  A_CTRL  = 2'd0;
  localparam logic [1:0]  A_CNT   = 2'd1;
  localparam logic [1:0]  A_CMP   = 2'd2;

  localparam int unsigned B_MATCH = 15;
  localparam int unsigned B_OVF   = 14;
  localparam int unsigned B_WPEND = 13;
  localparam int unsigned B_PER   = 8;
  localparam int unsigned B_IE    = 7;
  localparam int unsigned B_RT_LO = 4;
  localparam int unsigned B_CK_LO = 0;

  localparam int unsigned MAX_DIV = 128;
  localparam int unsigned PRE_W   = $clog2(MAX_DIV);

  typedef enum logic [1:0] {
    RT_NONE = 2'd0,
    RT_DMA  = 2'd1,
    RT_IRQ  = 2'd2,
    RT_RSVD = 2'd3
  } route_e;

  typedef enum logic [2:0] {
    CK_DIV8   = 3'd4,
    CK_DIV32  = 3'd5,
    CK_DIV128 = 3'd6,
    CK_DIV1   = 3'd7
  } cks_e;
endpackage

// File: rtl/cmt_sync.sv
module cmt_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/cmt_core.sv
module cmt_core
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             periodic_i,
  input  logic [2:0]       cks_i,
  input  logic             wr_req_i,
  input  logic             wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             snp_req_i,
  output logic             wr_ack_o,
  output logic             snp_ack_o,
  output logic [CNT_W-1:0] snap_o,
  output logic             match_tgl_o,
  output logic             ovf_tgl_o
);
  localparam int unsigned SW = 7;

  logic [SW-1:0] sync_q;
  logic run_s, per_s, wr_req_s, snp_req_s;
  logic [2:0] cks_s;

  cmt_sync #(.W(SW)) u_sync (
    .clk_i (ref_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({run_i, periodic_i, cks_i, wr_req_i, snp_req_i}),
    .q_o   (sync_q)
  );
  assign {run_s, per_s, cks_s, wr_req_s, snp_req_s} = sync_q;

  logic [CNT_W-1:0] cnt_q, cmp_q, snap_q;
  logic [PRE_W-1:0] pre_q;
  logic wr_req_d, snp_req_d, match_tgl_q, ovf_tgl_q;
  logic step_en, tick, load, load_cnt, load_cmp, at_cmp, at_top;

  always_comb begin
    unique case (cks_s)
      CK_DIV1:   step_en = 1'b1;
      CK_DIV8:   step_en = &pre_q[2:0];
      CK_DIV32:  step_en = &pre_q[4:0];
      CK_DIV128: step_en = &pre_q[PRE_W-1:0];
      default:   step_en = 1'b0;
    endcase
  end

  assign tick     = run_s & step_en;
  assign load     = wr_req_s ^ wr_req_d;
  assign load_cnt = load & ~wr_sel_i;
  assign load_cmp = load & wr_sel_i;
  assign at_cmp   = (cnt_q == cmp_q);
  assign at_top   = &cnt_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q       <= '0;
      cnt_q       <= '0;
      cmp_q       <= '1;
      snap_q      <= '0;
      wr_req_d    <= 1'b0;
      snp_req_d   <= 1'b0;
      match_tgl_q <= 1'b0;
      ovf_tgl_q   <= 1'b0;
    end else begin
      pre_q     <= run_s ? pre_q + 1'b1 : '0;
      wr_req_d  <= wr_req_s;
      snp_req_d <= snp_req_s;
      if (snp_req_s ^ snp_req_d) snap_q <= cnt_q;
      if (load_cmp) cmp_q <= wr_data_i;
      if (load_cnt) begin
        cnt_q <= wr_data_i;
      end else if (tick) begin
        if (at_cmp) match_tgl_q <= ~match_tgl_q;
        if (per_s && at_cmp) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          if (at_top) ovf_tgl_q <= ~ovf_tgl_q;
        end
      end
    end
  end

  assign wr_ack_o    = wr_req_d;
  assign snp_ack_o   = snp_req_d;
  assign snap_o      = snap_q;
  assign match_tgl_o = match_tgl_q;
  assign ovf_tgl_o   = ovf_tgl_q;
endmodule

// File: rtl/cmt_chan.sv
module cmt_chan
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              run_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic              dma_req_o,
  output logic              irq_o
);
  logic cmf_q, ovf_q, per_q, ie_q;
  logic [1:0] route_q;
  logic [2:0] cks_q;
  logic [CNT_W-1:0] cmp_sh_q, wr_data_q, cnt_rd_q, snap;
  logic wr_sel_q, wr_req_q, snp_req_q, match_d, ovf_d;
  logic wr_ack, snp_ack, match_tgl, ovf_tgl;
  logic wr_ack_s, snp_ack_s, match_s, ovf_s;
  logic wrflg, ctrl_wr, cnt_acc, cmp_acc, match_set, ovf_set;

  cmt_core #(.CNT_W(CNT_W)) u_core (
    .ref_clk_i  (ref_clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .periodic_i (per_q),
    .cks_i      (cks_q),
    .wr_req_i   (wr_req_q),
    .wr_sel_i   (wr_sel_q),
    .wr_data_i  (wr_data_q),
    .snp_req_i  (snp_req_q),
    .wr_ack_o   (wr_ack),
    .snp_ack_o  (snp_ack),
    .snap_o     (snap),
    .match_tgl_o(match_tgl),
    .ovf_tgl_o  (ovf_tgl)
  );

  cmt_sync #(.W(4)) u_bsync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wr_ack, snp_ack, match_tgl, ovf_tgl}),
    .q_o   ({wr_ack_s, snp_ack_s, match_s, ovf_s})
  );

  assign wrflg     = wr_req_q ^ wr_ack_s;
  assign ctrl_wr   = we_i && (addr_i == A_CTRL);
  assign cnt_acc   = we_i && (addr_i == A_CNT) && !wrflg;
  assign cmp_acc   = we_i && (addr_i == A_CMP) && !wrflg;
  assign match_set = match_s ^ match_d;
  assign ovf_set   = ovf_s ^ ovf_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmf_q     <= 1'b0;
      ovf_q     <= 1'b0;
      per_q     <= 1'b0;
      ie_q      <= 1'b0;
      route_q   <= RT_NONE;
      cks_q     <= '0;
      cmp_sh_q  <= '1;
      wr_data_q <= '0;
      wr_sel_q  <= 1'b0;
      wr_req_q  <= 1'b0;
      snp_req_q <= 1'b0;
      cnt_rd_q  <= '0;
      match_d   <= 1'b0;
      ovf_d     <= 1'b0;
    end else begin
      match_d <= match_s;
      ovf_d   <= ovf_s;
      cmf_q   <= match_set | (cmf_q & ~(ctrl_wr & ~wdata_i[B_MATCH]));
      ovf_q   <= ovf_set   | (ovf_q & ~(ctrl_wr & ~wdata_i[B_OVF]));
      if (ctrl_wr) begin
        per_q   <= wdata_i[B_PER];
        ie_q    <= wdata_i[B_IE];
        route_q <= wdata_i[B_RT_LO +: 2];
        cks_q   <= wdata_i[B_CK_LO +: 3];
      end
      if (cnt_acc || cmp_acc) begin
        wr_data_q <= wdata_i;
        wr_sel_q  <= cmp_acc;
        wr_req_q  <= ~wr_req_q;
      end
      if (cmp_acc) cmp_sh_q <= wdata_i;
      // snapshot round trip: copy only once the slow side has answered
      if (snp_ack_s == snp_req_q) begin
        cnt_rd_q  <= snap;
        snp_req_q <= ~snp_req_q;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[B_MATCH]       = cmf_q;
        rdata_o[B_OVF]         = ovf_q;
        rdata_o[B_WPEND]       = wrflg;
        rdata_o[B_PER]         = per_q;
        rdata_o[B_IE]          = ie_q;
        rdata_o[B_RT_LO +: 2]  = route_q;
        rdata_o[B_CK_LO +: 3]  = cks_q;
      end
      A_CNT:   rdata_o = cnt_rd_q;
      A_CMP:   rdata_o = cmp_sh_q;
      default: rdata_o = '0;
    endcase
  end

  assign dma_req_o = cmf_q && (route_q == RT_DMA);
  assign irq_o     = cmf_q && ie_q && (route_q == RT_IRQ);
endmodule

// File: rtl/cmt_chan_chk.sv
module cmt_chan_chk
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wd_match,
  input logic              wrflg,
  input logic [CNT_W-1:0]  wr_hold,
  input logic              cmf,
  input logic              ovf,
  input logic              match_set
);
  AST_WPEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wrflg && (addr_i == A_CNT || addr_i == A_CMP)) |=> wrflg); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrflg |=> $stable(wr_hold)); // R3

  AST_MATCH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL && !wd_match && !match_set) |=> !cmf); // R7

  AST_MATCH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmf && !(we_i && addr_i == A_CTRL)) |=> cmf); // R7

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !(we_i && addr_i == A_CTRL)) |=> ovf); // R6
endmodule

bind cmt_chan cmt_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wd_match (wdata_i[15]),
  .wrflg    (wrflg),
  .wr_hold  (wr_data_q),
  .cmf      (cmf_q),
  .ovf      (ovf_q),
  .match_set(match_set)
);

// File: tb/sim_cmt_chan.sv
`timescale 1ns/1ps
module sim_cmt_chan;
  logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic run = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic dma, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always #18 ref_clk = ~ref_clk;

  cmt_chan u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .run_i(run),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .dma_req_o(dma), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic refw(input int n);
    repeat (n) @(posedge ref_clk);
  endtask

  task automatic settle(input string req);
    logic [31:0] c;
    bit clr = 1'b0;
    for (int i = 0; i < 200 && !clr; i++) begin
      rd(2'd0, c);
      clr = !c[13];
    end
    chk(clr, req, {31'd0, !clr}, 32'd0);
    refw(12);
  endtask

  function automatic logic [31:0] ctl(input bit per, input bit ie, input logic [1:0] rt,
                                      input logic [2:0] ck, input bit km, input bit ko);
    return (32'(km) << 15) | (32'(ko) << 14) | (32'(per) << 8) | (32'(ie) << 7) |
           (32'(rt) << 4) | 32'(ck);
  endfunction

  initial begin
    logic [31:0] v, c1, c2;
    int unsigned div, expd, tol, dlt;
    bit ok;
    #23 rst_n = 1'b1;
    refw(4);

    // R1 reset state
    rd(2'd0, v); chk(v == 32'd0, "R1 ctrl reset", v, 32'd0);
    rd(2'd1, v); chk(v == 32'd0, "R1 count reset", v, 32'd0);
    rd(2'd2, v); chk(v == 32'hFFFF_FFFF, "R1 compare reset", v, 32'hFFFF_FFFF);
    chk(!irq && !dma, "R8 outputs idle", {30'd0, irq, dma}, 32'd0);

    // R2/R3 stopped counter: preload, then back-to-back writes
    wr(2'd0, ctl(1'b0, 1'b0, 2'd0, 3'd7, 1'b0, 1'b0));
    wr(2'd1, 32'd100); settle("R2 wpend clears");
    rd(2'd1, v); chk(v == 32'd100, "R2 count applied", v, 32'd100);
    wr(2'd1, 32'd7);
    rd(2'd1, v); chk(v == 32'd100, "R2 old value before crossing", v, 32'd100);
    rd(2'd0, v); chk(v[13], "R2 wpend set", v, v | 32'h2000);
    wr(2'd1, 32'd55);
    settle("R2 wpend clears");
    rd(2'd1, v); chk(v == 32'd7, "R3 write while pending ignored", v, 32'd7);

    // R5/R9 periodic with compare 9 at full rate
    wr(2'd2, 32'd9); settle("R2 wpend clears");
    rd(2'd2, v); chk(v == 32'd9, "R1 compare readback", v, 32'd9);
    wr(2'd1, 32'd0); settle("R2 wpend clears");
    wr(2'd0, ctl(1'b1, 1'b1, 2'd2, 3'd7, 1'b0, 1'b0));
    run = 1'b1;
    refw(40);
    rd(2'd0, v);
    chk(v[15], "R5 periodic match flag", v, v | 32'h8000);
    chk(!v[14], "R6 no overflow in periodic", v, v & ~32'h4000);
    ok = 1'b1; c2 = 0;
    for (int i = 0; i < 60; i++) begin
      rd(2'd1, v);
      if (v > 32'd9) begin ok = 1'b0; c2 = v; end
      refw(i % 3 + 1);
    end
    chk(ok, "R9 R5 reads stay within compare", c2, 32'd9);

    // R8 routing sweep with the flag held set
    for (int rt = 0; rt < 4; rt++) begin
      for (int e = 0; e < 2; e++) begin
        wr(2'd0, ctl(1'b1, e[0], rt[1:0], 3'd7, 1'b1, 1'b0));
        rd(2'd0, v);
        chk(irq == (rt == 2 && e == 1), "R8 irq routing", {31'd0, irq}, {31'd0, rt == 2 && e == 1});
        chk(dma == (rt == 1), "R8 dma routing", {31'd0, dma}, {31'd0, rt == 1});
      end
    end

    // R7 keep with 1, clear with 0
    run = 1'b0; refw(6);
    wr(2'd0, ctl(1'b1, 1'b1, 2'd2, 3'd7, 1'b1, 1'b0));
    rd(2'd0, v); chk(v[15] && irq, "R7 write 1 keeps flag", v, v | 32'h8000);
    wr(2'd0, ctl(1'b1, 1'b1, 2'd2, 3'd7, 1'b0, 1'b0));
    rd(2'd0, v); chk(!v[15], "R7 write 0 clears flag", v, v & ~32'h8000);
    chk(!irq, "R7 R8 irq drops with flag", {31'd0, irq}, 32'd0);

    // R6 free-running wrap
    wr(2'd0, ctl(1'b0, 1'b0, 2'd0, 3'd7, 1'b0, 1'b0));
    wr(2'd2, 32'd5); settle("R2 wpend clears");
    wr(2'd1, 32'hFFFF_FFF0); settle("R2 wpend clears");
    run = 1'b1; refw(40); run = 1'b0; refw(12);
    rd(2'd0, v);
    chk(v[14], "R6 overflow on wrap", v, v | 32'h4000);
    chk(v[15], "R6 match while free-running", v, v | 32'h8000);
    rd(2'd1, v);
    chk(v > 32'd5 && v < 32'd80, "R6 counter passes compare", v, 32'd40);

    // R4 rate sweep over all clock-select codes
    wr(2'd2, 32'hFFFF_FFFF); settle("R2 wpend clears");
    for (int ck = 0; ck < 8; ck++) begin
      run = 1'b0; refw(6);
      wr(2'd0, ctl(1'b0, 1'b0, 2'd0, ck[2:0], 1'b0, 1'b0));
      wr(2'd1, 32'd0); settle("R2 wpend clears");
      run = 1'b1; refw(8);
      rd(2'd1, c1);
      refw(1024);
      rd(2'd1, c2);
      dlt = c2 - c1;
      case (ck)
        4: div = 8; 5: div = 32; 6: div = 128; 7: div = 1; default: div = 0;
      endcase
      expd = (div == 0) ? 0 : 1024 / div;
      tol  = (div == 0) ? 0 : 8 / div + 2;
      chk((dlt + tol >= expd) && (dlt <= expd + tol), "R4 count rate per select", dlt, expd);
    end
    run = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0x00000000 expected=0x00000001");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule